// File: doc/BRIEF.md
# Peripheral Clock Source Slice

This block forms one slice of a peripheral clock tree. It is modelled entirely in a single system clock domain. Each candidate clock source arrives as a one-cycle enable strobe. The slice picks one of up to sixteen source strobes and passes the chosen strobe through a half-step rate divider. The result is a divided enable strobe that a peripheral can use as its clock enable.

One 32-bit control word, reached through a plain write/read port, sets everything: the source choice, an output enable, and the divider field. Two build-time options widen the slice:
- **UART option.** A flag in the control word can bypass the divider.
- **Audio option.** Primary selection code 7 acts as an escape. It hands the choice to a second 4-bit selector, which reaches source indices 8 and up.

Sources that the build marks as unpopulated behave as a strobe that is always low. The same applies to indices past the last source.

Top module: `perclk_slice`

## Requirements
- R1: Control bits [31:29] hold the primary source select. When the audio escape is not taken, the source index equals this value (0 to 7).
- R2: Control bit 28 is the output enable. While it is 0, `out_stb` stays low.
- R3: When the divider is in use, over N selected-source strobes (counted from a control write) the slice emits floor(2N/(F+2)) output strobes. F is control bits [7:0]. F=0 gives ratio 1, and F=1 gives two outputs per three inputs.
- R4: A control write clears the divider's accumulator and the strobe pipeline. The new setting therefore starts from a zero remainder.
- R5: With the UART option built in, control bit 24 = 0 makes the slice ignore F and divide by ratio 1. Bit 24 = 1 enables the divider.
- R6: With the audio option built in, the source index becomes 8 plus bits [19:16] when both of these hold: the primary select is 7, and bit 20 is 0. With bit 20 = 1, primary select 7 picks source 7.
- R7: Without the audio option, bits [20:16] have no effect, and primary select 7 always picks source 7.
- R8: An index that is past the last source, or that names a source whose build mask bit is 0, produces no output strobes.
- R9: `rd_data` is 0 after reset. From the cycle after a write, it returns the last written word.
- R10: A selected-source strobe sampled at one clock edge can produce an output strobe at the next edge, never sooner. Each output strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Last written control word |
| src_stb | input | NUM_SRC | One enable strobe per candidate source |
| out_stb | output | 1 | Divided, gated output strobe |

## Verification
The bench builds two slices side by side.

The first has both the UART and the audio options, with source 5 masked out of the build. This makes the bypass flag, the escape into indices 8 to 15, out-of-range escape codes and an unpopulated source all observable.

The second has neither option. Against it, the same escape code must fall back to plain source 7 while the divider still applies.

Each slice uses the default 8-bit divider field, so the extreme field value 255 and the 1.5 ratio both fall within a short counting window.

// File: rtl/perclk_pkg.sv
package perclk_pkg;
  localparam int CTRL_W   = 32;
  localparam int IDX_W    = 5;
  localparam int SEL_LSB  = 29;
  localparam int EN_BIT   = 28;
  localparam int UDIS_BIT = 24;
  localparam int XDIS_BIT = 20;
  localparam int XSEL_LSB = 16;
  localparam logic [2:0] ESC_CODE = 3'd7;

  // Effective source index; the escape path only exists in audio builds.
  function automatic logic [IDX_W-1:0] src_index(input logic [CTRL_W-1:0] c,
                                                 input bit audio);
    logic [IDX_W-1:0] r;
    r = {2'b00, c[SEL_LSB +: 3]};
    if (audio && (c[SEL_LSB +: 3] == ESC_CODE) && !c[XDIS_BIT])
      r = 5'd8 + {1'b0, c[XSEL_LSB +: 4]};
    return r;
  endfunction
endpackage

// File: rtl/perclk_ctrl.sv
module perclk_ctrl
  import perclk_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter bit UART_MODE  = 1'b0,
  parameter bit AUDIO_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [IDX_W-1:0]  src_idx,
  output logic              out_en,
  output logic [DIV_W:0]    divisor
);
  localparam logic [DIV_W:0] UNITY = (DIV_W+1)'(2);

  logic div_use;

  always_ff @(posedge clk) begin
    if (rst)        ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  generate
    if (UART_MODE) begin : g_uart
      assign div_use = ctrl_q[UDIS_BIT];
    end else begin : g_plain
      assign div_use = 1'b1;
    end
  endgenerate

  assign src_idx = src_index(ctrl_q, AUDIO_MODE);
  assign out_en  = ctrl_q[EN_BIT];
  assign divisor = div_use ? ({1'b0, ctrl_q[DIV_W-1:0]} + UNITY) : UNITY;
endmodule

// File: rtl/perclk_src_sel.sv
module perclk_src_sel
  import perclk_pkg::*;
#(
  parameter int               NUM_SRC  = 16,
  parameter logic [NUM_SRC-1:0] SRC_MASK = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] src_stb,
  input  logic [IDX_W-1:0]   src_idx,
  output logic               sel_stb
);
  localparam int PAD_W = 1 << IDX_W;

  logic [NUM_SRC-1:0] live;
  logic [PAD_W-1:0]   live_pad;

  assign live     = src_stb & SRC_MASK;
  assign live_pad = {{(PAD_W-NUM_SRC){1'b0}}, live};

  always_ff @(posedge clk) begin
    if (rst || clr) sel_stb <= 1'b0;
    else            sel_stb <= live_pad[src_idx];
  end
endmodule

// File: rtl/perclk_frac_div.sv
module perclk_frac_div #(
  parameter int DIV_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           stb_in,
  input  logic           en,
  input  logic [DIV_W:0] divisor,
  output logic           stb_out
);
  localparam int ACC_W = DIV_W + 2;
  localparam logic [ACC_W-1:0] STEP = ACC_W'(2);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] dv;

  assign dv  = {1'b0, divisor};
  assign sum = acc + STEP;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc     <= '0;
      stb_out <= 1'b0;
    end else begin
      stb_out <= 1'b0;
      if (stb_in) begin
        if (sum >= dv) begin
          acc     <= sum - dv;
          stb_out <= en;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/perclk_slice.sv
module perclk_slice
  import perclk_pkg::*;
#(
  parameter int                 NUM_SRC    = 16,
  parameter int                 DIV_W      = 8,
  parameter bit                 UART_MODE  = 1'b0,
  parameter bit                 AUDIO_MODE = 1'b0,
  parameter logic [NUM_SRC-1:0] SRC_MASK   = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [31:0]        wr_data,
  output logic [31:0]        rd_data,
  input  logic [NUM_SRC-1:0] src_stb,
  output logic               out_stb
);
  logic [IDX_W-1:0] src_idx;
  logic             out_en;
  logic [DIV_W:0]   divisor;
  logic             sel_stb;

  perclk_ctrl #(
    .DIV_W(DIV_W), .UART_MODE(UART_MODE), .AUDIO_MODE(AUDIO_MODE)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(rd_data), .src_idx(src_idx), .out_en(out_en), .divisor(divisor)
  );

  perclk_src_sel #(
    .NUM_SRC(NUM_SRC), .SRC_MASK(SRC_MASK)
  ) u_sel (
    .clk(clk), .rst(rst), .clr(wr_en), .src_stb(src_stb),
    .src_idx(src_idx), .sel_stb(sel_stb)
  );

  perclk_frac_div #(
    .DIV_W(DIV_W)
  ) u_div (
    .clk(clk), .rst(rst), .clr(wr_en), .stb_in(sel_stb),
    .en(out_en), .divisor(divisor), .stb_out(out_stb)
  );
endmodule

// File: rtl/perclk_slice_chk.sv
module perclk_slice_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        sel_stb,
  input logic        out_stb
);
  // R10: an output strobe needs a selected strobe one edge earlier
  p_out_after_sel_r10: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> $past(sel_stb));

  // R10: output strobes are single-cycle pulses (divisor is at least 2 half-units)
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> (!out_stb || $past(sel_stb)));

  // R2: enable clear in the word in force means no output
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_data[28]) |-> !out_stb);

  // R4: a write flushes the pipeline
  p_write_flush_r4: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (!out_stb && !sel_stb));

  // R9: readback follows the last write
  p_readback_r9: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> (rd_data == $past(wr_data)));

  // R9: without a write the word holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(rd_data));
endmodule

bind perclk_slice perclk_slice_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sel_stb(sel_stb), .out_stb(out_stb)
);

// File: tb/sim_perclk_slice.sv
module sim_perclk_slice;
  localparam int NS = 16;
  localparam int N  = 510;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en0 = 1'b0, wr_en1 = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd0, rd1;
  logic [NS-1:0] src = '0;
  logic          out0, out1;

  int checks = 0, fails = 0;
  int q_exp[$];
  int q_dev[$];
  string q_tag[$];
  int win_cnt = 0;
  logic win_end = 1'b0;

  always #10 clk = ~clk;

  perclk_slice #(.UART_MODE(1'b1), .AUDIO_MODE(1'b1), .SRC_MASK(16'hFFDF)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en0), .wr_data(wr_data), .rd_data(rd0),
    .src_stb(src), .out_stb(out0));

  perclk_slice #(.UART_MODE(1'b0), .AUDIO_MODE(1'b0)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr_en1), .wr_data(wr_data), .rd_data(rd1),
    .src_stb(src), .out_stb(out1));

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  function automatic logic [31:0] mk(int sel, bit en, bit udis, bit xdis, int xsel, int fld);
    return (32'(sel) << 29) | (32'(en) << 28) | (32'(udis) << 24) |
           (32'(xdis) << 20) | (32'(xsel & 15) << 16) | 32'(fld & 255);
  endfunction

  task automatic wr(input int dev, input logic [31:0] v);
    wr_data = v;
    if (dev == 0) wr_en0 = 1'b1; else wr_en1 = 1'b1;
    tick();
    wr_en0 = 1'b0; wr_en1 = 1'b0;
  endtask

  // Driver: write, push expected count, strobe the chosen line every other
  // cycle while every other line stays high, then drain and close the window.
  task automatic window(input int dev, input logic [31:0] v, input int s,
                        input int exp, input string tag);
    wr(dev, v);
    q_exp.push_back(exp); q_dev.push_back(dev); q_tag.push_back(tag);
    for (int i = 0; i < 2*N; i++) begin
      src = '1;
      src[s] = (i % 2 == 0);
      tick();
    end
    src = '0;
    repeat (4) tick();
    win_end = 1'b1;
    tick();
    win_end = 1'b0;
    tick();
  endtask

  // Monitor: counts strobes of the device under test and scores the window.
  always @(negedge clk) begin
    if (!rst && q_exp.size() > 0) begin
      if ((q_dev[0] == 0 && out0) || (q_dev[0] == 1 && out1)) win_cnt++;
      if (win_end) begin
        int e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        void'(q_dev.pop_front());
        check(win_cnt, e, t);
        win_cnt = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check(int'(rd0), 0, "R9 reset readback");
    check(int'(out0), 0, "R2 reset output low");

    // R9 readback
    wr(0, 32'hA5C3_1234);
    check(int'(rd0 == 32'hA5C3_1234), 1, "R9 readback of written word");

    // R10 latency: one strobe, output two edges later, one cycle wide
    wr(0, mk(0, 1, 0, 1, 0, 0));
    src[0] = 1'b1; tick(); src = '0;
    check(int'(out0), 0, "R10 no output one edge after strobe");
    tick();
    check(int'(out0), 1, "R10 output two edges after strobe");
    tick();
    check(int'(out0), 0, "R10 output lasts one cycle");

    // R4: a rewrite drops the remainder (ratio 2/3 needs two strobes from zero)
    wr(0, mk(0, 1, 1, 1, 0, 1));
    src[0] = 1'b1; tick(); src = '0;
    repeat (3) tick();
    wr(0, mk(0, 1, 1, 1, 0, 1));
    c = 0;
    for (int i = 0; i < 6; i++) begin
      src[0] = (i < 2);
      tick();
      if (out0) c++;
    end
    src = '0;
    check(c, 1, "R4 write clears accumulator");

    // R3 ratios on source 2 with the divider in use
    window(0, mk(2, 1, 1, 1, 0, 0),   2, (2*N)/2,   "R3 field 0");
    window(0, mk(2, 1, 1, 1, 0, 1),   2, (2*N)/3,   "R3 field 1");
    window(0, mk(2, 1, 1, 1, 0, 2),   2, (2*N)/4,   "R3 field 2");
    window(0, mk(2, 1, 1, 1, 0, 255), 2, (2*N)/257, "R3 field 255");
    window(1, mk(2, 1, 0, 0, 0, 3),   2, (2*N)/5,   "R3 plain slice field 3");

    // R2 enable clear
    window(0, mk(2, 0, 1, 1, 0, 0), 2, 0, "R2 enable clear");

    // R5 UART bypass
    window(0, mk(3, 1, 0, 1, 0, 5), 3, N,         "R5 bypass ignores field");
    window(0, mk(3, 1, 1, 1, 0, 5), 3, (2*N)/7,   "R5 divider enabled");

    // R1 primary select (source 5 is masked out, see R8)
    for (int s = 0; s < 8; s++) begin
      if (s != 5) window(0, mk(s, 1, 1, 1, 0, 0), s, N, $sformatf("R1 primary %0d", s));
    end

    // R6 audio escape to sources 8..15
    for (int k = 0; k < 8; k++)
      window(0, mk(7, 1, 1, 0, k, 0), 8 + k, N, $sformatf("R6 escape index %0d", 8 + k));

    // R8 unpopulated and past-the-end indices
    window(0, mk(5, 1, 1, 1, 0, 0), 5, 0, "R8 unpopulated source 5");
    window(0, mk(7, 1, 1, 0, 9, 0), 1, 0, "R8 escape past last source");

    // R7 plain slice ignores the escape fields
    window(1, mk(7, 1, 0, 0, 1, 0), 7, N, "R7 plain slice select 7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule